// File: doc/BRIEF.md
# Two-Tier Chipkill Line Protection Engine

This engine sits on the controller side of a memory made of nine devices. Each device is modelled as a plain synchronous array. Every 64-byte line is stored whole in a single device, next to an 8-bit checksum of its bytes. Nine devices form a stripe row: eight hold data lines and one holds their XOR parity. The parity device moves one device lower on each successive stripe row.

In the common case the engine reads a line from its own device only and verifies the checksum. A write reads the old line and the old parity, then writes the new line and the updated parity. These two devices are the only ones involved. A checksum mismatch makes the engine read the whole stripe row in one cycle and rebuild the line from the other eight words. If the rebuilt line passes its checksum, it is written back and reported as corrected. Otherwise the request ends as uncorrectable and nothing is written.

A fault-injection operation flips data bits of a stored line in place, so the recovery paths can be exercised. Requests are served one at a time through a valid/ready pair. Responses are held until the requester accepts them.

Top module: `chipkill_engine`

## Requirements
- R1: After reset the engine clears every row of every device to zero, one row per cycle. It holds `req_ready` low for exactly STRIPES cycles. A later read of a line that was never written returns all zeros with status clean.
- R2: A read of an intact line returns the stored bytes with status 0 (clean). During that request only the line's own device is enabled.
- R3: Line address a lies in stripe row s = a / 8 at data slot k = a % 8. The parity device of row s is 8 - (s mod 9). Slot k is held by device k if k is below the parity device, and by device k+1 otherwise. Device i is bit i of `dev_access`.
- R4: A write (op 1) enables only the line's device and its row's parity device. It answers with status 0.
- R5: The stored checksum is the 8-bit ones'-complement sum (end-around carry) of the 64 data bytes. Any single flipped data bit therefore makes it mismatch.
- R6: A read of a line with a checksum mismatch proceeds as follows, provided the rest of its row is intact:
  - it enables all nine devices in one cycle;
  - it returns the original bytes with status 1 (corrected);
  - it pulses `fix_pulse` for exactly one cycle while writing the line back;
  - a repeated read is then clean.
- R7: If the rebuilt line also fails its checksum, for example because two lines of one row are damaged, the read returns status 2 (uncorrectable). No write-back and no `fix_pulse` occur, so a repeated read is again uncorrectable.
- R8: An inject request (op 2) XORs `req_wdata` into the stored data bytes of the addressed line. It leaves the checksum and the parity untouched, enables only that line's device, and answers with status 0. Op 3 acts as a read.
- R9: `req_ready` is high only when the engine is idle and no response is pending. While `resp_valid` is high and `resp_ready` is low, the response data and status stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine accepts a request this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 inject, 3 read |
| req_addr | input | 7 | Line address |
| req_wdata | input | 512 | Write data or inject mask |
| resp_valid | output | 1 | Response available |
| resp_ready | input | 1 | Requester takes the response |
| resp_status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| resp_data | output | 512 | Line bytes for reads |
| dev_access | output | 9 | Per-device enable in the current cycle |
| fix_pulse | output | 1 | A corrected line is being written back |

## Verification
The assertions watch, on every cycle, the following properties:
- more than two devices are never active except while clearing or gathering a row;
- a write-back pulse lasts one cycle and is followed by a corrected response;
- a pending response stays stable;
- ready and a pending response never coincide;
- the decoded data and parity devices always differ.

Only the bench scenarios can show the remaining behaviours:
- that the returned bytes, statuses and per-request device masks match the row mapping;
- that a correction really heals the line;
- that double damage stays uncorrectable across repeated reads.

// File: rtl/ck_pkg.sv
package ck_pkg;

    localparam logic [1:0] OP_READ   = 2'd0;
    localparam logic [1:0] OP_WRITE  = 2'd1;
    localparam logic [1:0] OP_INJECT = 2'd2;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_FIXED = 2'd1,
        ST_UNCOR = 2'd2
    } resp_stat_t;

    typedef enum logic [3:0] {
        S_CLEAR,
        S_IDLE,
        S_RD_ISSUE,
        S_RD_CHECK,
        S_GATHER,
        S_REBUILD,
        S_WRITEBACK,
        S_WR_ISSUE,
        S_WR_COMMIT,
        S_INJ_ISSUE,
        S_INJ_COMMIT,
        S_RESP
    } eng_state_t;

endpackage

// File: rtl/ck_dev_array.sv
module ck_dev_array #(
    parameter int WORDW = 520,
    parameter int DEPTH = 16,
    localparam int RW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [RW-1:0]    row,
    input  logic [WORDW-1:0] wword,
    output logic [WORDW-1:0] rword
);
    logic [WORDW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                cells[row] <= wword;
            end else begin
                rword <= cells[row];
            end
        end
    end
endmodule

// File: rtl/ck_csum.sv
module ck_csum #(
    parameter int NBYTES = 64
) (
    input  logic [NBYTES*8-1:0] bytes_in,
    output logic [7:0]          sum
);
    logic [8:0] acc;

    always_comb begin
        acc = 9'd0;
        for (int i = 0; i < NBYTES; i++) begin
            acc = {1'b0, acc[7:0]} + {1'b0, bytes_in[i*8 +: 8]};
            acc = {1'b0, acc[7:0]} + {8'd0, acc[8]};
        end
        sum = acc[7:0];
    end
endmodule

// File: rtl/ck_addr_map.sv
module ck_addr_map #(
    parameter int NDEV    = 9,
    parameter int STRIPES = 16,
    localparam int DPS = NDEV - 1,
    localparam int AW  = $clog2(STRIPES * DPS),
    localparam int SW  = (STRIPES > 1) ? $clog2(STRIPES) : 1,
    localparam int DW  = $clog2(NDEV)
) (
    input  logic [AW-1:0] addr,
    output logic [SW-1:0] stripe,
    output logic [DW-1:0] ddev,
    output logic [DW-1:0] pdev
);
    int unsigned a_i, s_i, k_i, p_i;

    always_comb begin
        a_i = 32'(addr);
        s_i = a_i / DPS;
        k_i = a_i % DPS;
        p_i = (NDEV - 1) - (s_i % NDEV);
        stripe = SW'(s_i);
        pdev   = DW'(p_i);
        ddev   = (k_i < p_i) ? DW'(k_i) : DW'(k_i + 1);
    end
endmodule

// File: rtl/chipkill_engine.sv
module chipkill_engine
    import ck_pkg::*;
#(
    parameter int NDEV       = 9,
    parameter int LINE_BYTES = 64,
    parameter int STRIPES    = 16,
    localparam int DATAW = LINE_BYTES * 8,
    localparam int WORDW = DATAW + 8,
    localparam int DPS   = NDEV - 1,
    localparam int AW    = $clog2(STRIPES * DPS),
    localparam int SW    = (STRIPES > 1) ? $clog2(STRIPES) : 1,
    localparam int DW    = $clog2(NDEV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [AW-1:0]    req_addr,
    input  logic [DATAW-1:0] req_wdata,
    output logic             resp_valid,
    input  logic             resp_ready,
    output logic [1:0]       resp_status,
    output logic [DATAW-1:0] resp_data,
    output logic [NDEV-1:0]  dev_access,
    output logic             fix_pulse
);
    eng_state_t state, nstate;

    logic [1:0]       op_q;
    logic [AW-1:0]    addr_q;
    logic [DATAW-1:0] wdata_q;
    logic [SW-1:0]    clr_cnt;
    logic [DATAW-1:0] rdata_q;
    resp_stat_t       rstat_q;
    logic [WORDW-1:0] recon_q;

    logic [SW-1:0]    stripe;
    logic [DW-1:0]    ddev, pdev;

    logic [NDEV-1:0]  dv_en, dv_we;
    logic [SW-1:0]    dv_row;
    logic [WORDW-1:0] dv_wword [NDEV];
    logic [WORDW-1:0] dv_rword [NDEV];

    logic [WORDW-1:0] own_word, par_word, recon;
    logic [DATAW-1:0] chk_bytes;
    logic [7:0]       chk_sum, new_sum;
    logic             own_ok, recon_ok;

    ck_addr_map #(.NDEV(NDEV), .STRIPES(STRIPES)) u_map (
        .addr(addr_q), .stripe(stripe), .ddev(ddev), .pdev(pdev)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NDEV; gi++) begin : g_dev
            ck_dev_array #(.WORDW(WORDW), .DEPTH(STRIPES)) u_dev (
                .clk(clk), .en(dv_en[gi]), .we(dv_we[gi]), .row(dv_row),
                .wword(dv_wword[gi]), .rword(dv_rword[gi])
            );
        end
    endgenerate

    // Word layout: {data bytes, checksum byte}.
    assign own_word = dv_rword[ddev];
    assign par_word = dv_rword[pdev];

    always_comb begin
        recon = '0;
        for (int i = 0; i < NDEV; i++) begin
            if (DW'(i) != ddev) recon = recon ^ dv_rword[i];
        end
    end

    assign chk_bytes = (state == S_REBUILD) ? recon[WORDW-1:8] : own_word[WORDW-1:8];

    ck_csum #(.NBYTES(LINE_BYTES)) u_chk (.bytes_in(chk_bytes), .sum(chk_sum));
    ck_csum #(.NBYTES(LINE_BYTES)) u_new (.bytes_in(wdata_q),   .sum(new_sum));

    assign own_ok   = (chk_sum == own_word[7:0]);
    assign recon_ok = (chk_sum == recon[7:0]);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_CLEAR;
        else        state <= nstate;
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_CLEAR:      if (clr_cnt == SW'(STRIPES - 1)) nstate = S_IDLE;
            S_IDLE: begin
                if (req_valid) begin
                    unique case (req_op)
                        OP_WRITE:  nstate = S_WR_ISSUE;
                        OP_INJECT: nstate = S_INJ_ISSUE;
                        default:   nstate = S_RD_ISSUE;
                    endcase
                end
            end
            S_RD_ISSUE:   nstate = S_RD_CHECK;
            S_RD_CHECK:   nstate = own_ok ? S_RESP : S_GATHER;
            S_GATHER:     nstate = S_REBUILD;
            S_REBUILD:    nstate = recon_ok ? S_WRITEBACK : S_RESP;
            S_WRITEBACK:  nstate = S_RESP;
            S_WR_ISSUE:   nstate = S_WR_COMMIT;
            S_WR_COMMIT:  nstate = S_RESP;
            S_INJ_ISSUE:  nstate = S_INJ_COMMIT;
            S_INJ_COMMIT: nstate = S_RESP;
            S_RESP:       if (resp_ready) nstate = S_IDLE;
            default:      nstate = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_cnt <= '0;
            op_q    <= OP_READ;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            rstat_q <= ST_CLEAN;
            recon_q <= '0;
        end else begin
            unique case (state)
                S_CLEAR: clr_cnt <= clr_cnt + 1'b1;
                S_IDLE: begin
                    if (req_valid) begin
                        op_q    <= req_op;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                    end
                end
                S_RD_CHECK: begin
                    rdata_q <= own_word[WORDW-1:8];
                    rstat_q <= ST_CLEAN;
                end
                S_REBUILD: begin
                    recon_q <= recon;
                    rdata_q <= recon[WORDW-1:8];
                    rstat_q <= recon_ok ? ST_FIXED : ST_UNCOR;
                end
                S_WR_COMMIT, S_INJ_COMMIT: begin
                    rdata_q <= '0;
                    rstat_q <= ST_CLEAN;
                end
                default: ;
            endcase
        end
    end

    // Outputs and device controls
    always_comb begin
        dv_en  = '0;
        dv_we  = '0;
        dv_row = stripe;
        for (int i = 0; i < NDEV; i++) dv_wword[i] = '0;
        unique case (state)
            S_CLEAR: begin
                dv_en  = '1;
                dv_we  = '1;
                dv_row = clr_cnt;
            end
            S_RD_ISSUE, S_INJ_ISSUE: dv_en[ddev] = 1'b1;
            S_GATHER:                dv_en = '1;
            S_WRITEBACK: begin
                dv_en[ddev]    = 1'b1;
                dv_we[ddev]    = 1'b1;
                dv_wword[ddev] = recon_q;
            end
            S_WR_ISSUE: begin
                dv_en[ddev] = 1'b1;
                dv_en[pdev] = 1'b1;
            end
            S_WR_COMMIT: begin
                dv_en[ddev]    = 1'b1;
                dv_en[pdev]    = 1'b1;
                dv_we[ddev]    = 1'b1;
                dv_we[pdev]    = 1'b1;
                dv_wword[ddev] = {wdata_q, new_sum};
                dv_wword[pdev] = par_word ^ own_word ^ {wdata_q, new_sum};
            end
            S_INJ_COMMIT: begin
                dv_en[ddev]    = 1'b1;
                dv_we[ddev]    = 1'b1;
                dv_wword[ddev] = own_word ^ {wdata_q, 8'h00};
            end
            default: ;
        endcase
    end

    assign req_ready   = (state == S_IDLE);
    assign resp_valid  = (state == S_RESP);
    assign resp_status = rstat_q;
    assign resp_data   = rdata_q;
    assign dev_access  = dv_en;
    assign fix_pulse   = (state == S_WRITEBACK);

    // R2 R4 R6: more than two devices busy only while clearing or gathering a row
    wide_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(dev_access) > 2) |-> (state == S_CLEAR || state == S_GATHER));

    // R6
    fix_then_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix_pulse |=> (!fix_pulse && resp_valid && resp_status == ST_FIXED));

    // R9
    resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data) && $stable(resp_status)));

    // R9
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && resp_valid));

    // R3
    par_data_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_CLEAR) |-> (ddev != pdev));

endmodule

// File: tb/tb_chipkill_engine.sv
`timescale 1ns/1ps
module tb_chipkill_engine;
    localparam int NDEV = 9, STRIPES = 16, LINES = STRIPES * 8, AW = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, resp_ready = 1'b0;
    logic req_ready, resp_valid, fix_pulse;
    logic [1:0] req_op = '0, resp_status;
    logic [AW-1:0] req_addr = '0;
    logic [511:0] req_wdata = '0, resp_data;
    logic [NDEV-1:0] dev_access;

    chipkill_engine dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_status(resp_status),
        .resp_data(resp_data), .dev_access(dev_access), .fix_pulse(fix_pulse)
    );

    always #2 clk = ~clk;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    // Behavioural reference: good contents and damage flags per line
    logic [511:0] good [LINES];
    bit           bad  [LINES];
    logic [NDEV-1:0] seen_mask;
    int  seen_fix;
    logic [1:0]   got_stat;
    logic [511:0] got_data;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int pdev_of(input int a);
        return 8 - ((a / 8) % 9);
    endfunction
    function automatic int ddev_of(input int a);
        int k = a % 8;
        return (k < pdev_of(a)) ? k : k + 1;
    endfunction
    function automatic logic [511:0] mkline(input int seed);
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = (seed + 1) * 32'h9E3779B1 ^ (i * 32'h01010101);
        return v;
    endfunction

    // Model cycle check every negedge: handshake flags are mutually exclusive (R9)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (req_ready && resp_valid) chk(1'b0, "R9", "ready with pending resp", 1, 0);
        end
    end

    task automatic do_req(input logic [1:0] op, input int a, input logic [511:0] d, input int hold);
        logic [1:0] s0; logic [511:0] d0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        seen_mask = '0; seen_fix = 0;
        while (!resp_valid) begin
            seen_mask = seen_mask | dev_access;
            if (fix_pulse) seen_fix++;
            if (req_ready) chk(1'b0, "R9", "ready while busy", 1, 0);
            @(negedge clk);
        end
        got_stat = resp_status; got_data = resp_data;
        s0 = resp_status; d0 = resp_data;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(resp_valid && resp_status == s0 && resp_data == d0, "R9", "held response", resp_data, d0);
            chk(!req_ready, "R9", "ready during hold", req_ready, 0);
        end
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
    endtask

    task automatic read_expect(input int a, input string req);
        int cnt = 0, pd = pdev_of(a);
        bit other_bad = 1'b0;
        for (int j = (a / 8) * 8; j < (a / 8) * 8 + 8; j++) if (j != a && bad[j]) other_bad = 1'b1;
        do_req(2'd0, a, '0, 0);
        if (!bad[a]) begin
            chk(got_stat == 2'd0, req, "clean status", got_stat, 0);
            chk(got_data == good[a], req, "clean data", got_data, good[a]);
            chk(seen_mask == NDEV'(1 << ddev_of(a)), req, "single device", seen_mask, 1 << ddev_of(a));
        end else if (!other_bad) begin
            chk(got_stat == 2'd1, "R6", "corrected status", got_stat, 1);
            chk(got_data == good[a], "R6", "corrected data", got_data, good[a]);
            chk(seen_mask == '1, "R6", "all devices", seen_mask, 9'h1FF);
            chk(seen_fix == 1, "R6", "one fix pulse", seen_fix, 1);
            bad[a] = 1'b0;
        end else begin
            chk(got_stat == 2'd2, "R7", "uncorrectable status", got_stat, 2);
            chk(seen_fix == 0, "R7", "no write-back", seen_fix, 0);
            chk(seen_mask == '1, "R7", "all devices", seen_mask, 9'h1FF);
        end
        if (pd < 0) cnt++;
    endtask

    task automatic write_line(input int a, input logic [511:0] d);
        do_req(2'd1, a, d, 0);
        good[a] = d;
        // R4 R3: data device plus parity device of the row
        chk(got_stat == 2'd0, "R4", "write status", got_stat, 0);
        chk(seen_mask == NDEV'((1 << ddev_of(a)) | (1 << pdev_of(a))), "R4", "write devices",
            seen_mask, (1 << ddev_of(a)) | (1 << pdev_of(a)));
    endtask

    task automatic inject(input int a, input int bitpos);
        logic [511:0] m = '0;
        m[bitpos] = 1'b1;
        do_req(2'd2, a, m, 0);
        bad[a] = 1'b1;
        chk(got_stat == 2'd0, "R8", "inject status", got_stat, 0);
        chk(seen_mask == NDEV'(1 << ddev_of(a)), "R8", "inject device", seen_mask, 1 << ddev_of(a));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int cyc;
        for (int i = 0; i < LINES; i++) begin good[i] = '0; bad[i] = 1'b0; end
        repeat (3) @(negedge clk);
        chk(!req_ready && !resp_valid, "R1", "reset state", {req_ready, resp_valid}, 0);
        rst_n = 1'b1;
        cyc = 0;
        @(negedge clk);
        cyc = 1;
        while (!req_ready && cyc < 100) begin @(negedge clk); cyc++; end
        chk(cyc == STRIPES, "R1", "clear cycles", cyc, STRIPES);

        // R1: untouched lines read zero; R2/R3 single-device reads
        read_expect(5, "R1");
        read_expect(127, "R1");

        // R3 R4: writes across rows with rotating parity
        for (int s = 0; s < 10; s++) write_line(s * 8 + (s % 8), mkline(s));
        write_line(1, mkline(40));
        write_line(2, mkline(41));
        write_line(71, {64{8'hFF}});
        write_line(64, mkline(42));
        for (int s = 0; s < 10; s++) read_expect(s * 8 + (s % 8), "R2");
        read_expect(71, "R3");
        read_expect(64, "R3");

        // R5 R6: single flip in all-0xFF line (row 8, parity device 0), then heal
        inject(71, 3);
        read_expect(71, "R5");
        read_expect(71, "R6");
        // R6: row 0 line, parity device 8
        inject(1, 300);
        read_expect(1, "R6");
        read_expect(1, "R6");
        // R6 on a line never written explicitly
        inject(60, 511);
        read_expect(60, "R6");

        // R7: two damaged lines in one row
        inject(2, 10);
        inject(0, 20);
        read_expect(2, "R7");
        read_expect(2, "R7");

        // R9: response held while requester stalls
        do_req(2'd0, 64, '0, 4);
        chk(got_data == good[64] && got_stat == 2'd0, "R9", "held read value", got_data, good[64]);

        // R8: op 3 behaves as read
        do_req(2'd3, 9, '0, 0);
        chk(got_data == good[9] && got_stat == 2'd0, "R8", "op3 read", got_data, good[9]);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule